// File: doc/BRIEF.md
# Operand Address Modification Sequencer

This block takes the address part of a decoded instruction and forms the effective A and B operand addresses. The two operand addresses are three 6-bit characters each. They are supplied as 18-bit values with the most significant character in the top six bits. A one-character modifier field carries two octal digits. The high digit applies to the A address and the low digit applies to the B address. A digit of zero leaves its address alone. A register digit adds the live program counter (digit 4) or the T register (digit 6). Any other nonzero digit adds an 18-bit index word read from a fixed three-character memory slot. All sums wrap modulo 2^18.

The sequencer keeps time in 15 µs ticks, and each clock cycle is one tick. Decode occupies two ticks and each modified address occupies six. An optional store of the A register adds one final tick. The A address is always handled before the B address. Index words are read through a plain request/response port. A slow response stretches the modification phase until the index is available. A one-cycle `done` pulse marks the final tick. The effective addresses are valid at that point and hold until the next accepted start.

Top module: `addr_mod_seq`

## Requirements
- R1: `a_field` and `b_field` are 18-bit addresses (three 6-bit characters, most significant first); a modifier digit of 0 leaves the corresponding effective address equal to the field.
- R2: `n_field[5:3]` is the digit for the A address and `n_field[2:0]` is the digit for the B address.
- R3: Digits 1, 2, 3, 5 and 7 read the index word at `mem_rd_addr` 111, 221, 131 and 151 and 171 respectively. The read is one 18-bit word. `mem_rd_req` and `mem_rd_addr` stay steady until `mem_rd_valid` is seen.
- R4: Digit 4 adds `pc_val` and digit 6 adds `t_val`. Both are sampled in the cycle the start is accepted, and neither causes a memory read.
- R5: Each modified address equals field plus index, modulo 2^18.
- R6: With a fast memory, `busy` is high for 2 + 6·m + s cycles, where m is the number of nonzero digits and s is the store flag. `done` is high only in the last of those cycles. With m = 0 and s = 0, `done` comes on the second decode tick.
- R7: `store_en` = 1 at start adds exactly one tick after the last modification, or after decode if there is none.
- R8: When both addresses need memory, the A slot is requested before the B slot.
- R9: A modification phase lasts at least 6 cycles, and ends no earlier than the second cycle after the one carrying `mem_rd_valid`.
- R10: `start` while `busy` is ignored: it changes neither the results nor the timing.
- R11: During reset `busy`, `done` and `mem_rd_req` are low and both effective addresses are zero. After `done`, the effective addresses hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted when idle) |
| a_field | input | 18 | A operand address |
| b_field | input | 18 | B operand address |
| n_field | input | 6 | Modifier character: A digit [5:3], B digit [2:0] |
| store_en | input | 1 | Add the A-register store tick |
| pc_val | input | 18 | Program counter value |
| t_val | input | 18 | T register value |
| mem_rd_req | output | 1 | Index word read request |
| mem_rd_addr | output | 18 | Slot address of the index word |
| mem_rd_valid | input | 1 | Read response strobe |
| mem_rd_data | input | 18 | Index word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final tick of the sequence |
| eff_a | output | 18 | Effective A address |
| eff_b | output | 18 | Effective B address |

## Verification
The bench sweeps all 64 modifier characters, each with and without the store tick, and computes the addresses and the cycle counts arithmetically. Each digit decodes to a different index source. A swapped digit or a wrong slot shows up as a wrong sum or a wrong request address, and a reversed order shows up in the request log. Some cases push the sums past 2^18: a design without wraparound would produce out-of-range sums there. The bench also changes `pc_val` and `t_val` after the start is accepted, so a design that sampled them late would add the wrong value. Further runs use a memory slower than six ticks, which a design that ends the phase on its count alone would finish before the index arrives. A start during a running sequence catches a design that restarts instead of ignoring it.

// File: rtl/amod_pkg.sv
package amod_pkg;
  localparam int CHAR_W     = 6;
  localparam int ADDR_CHARS = 3;
  localparam int AW         = CHAR_W * ADDR_CHARS;
  localparam int DIG_W      = 3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DECODE, PH_MOD_A, PH_MOD_B, PH_STORE
  } phase_e;

  typedef enum logic [1:0] {
    SRC_NONE, SRC_MEM, SRC_PC, SRC_T
  } src_e;

  // Memory-resident index slots follow 101 + 10*digit, except digit 2.
  function automatic logic [AW-1:0] slot_base(input logic [DIG_W-1:0] d);
    if (d == 3'd2) return AW'(221);
    return AW'(101 + 10 * int'(d));
  endfunction

  function automatic src_e digit_src(input logic [DIG_W-1:0] d);
    case (d)
      3'd0:    return SRC_NONE;
      3'd4:    return SRC_PC;
      3'd6:    return SRC_T;
      default: return SRC_MEM;
    endcase
  endfunction
endpackage

// File: rtl/amod_index_src.sv
module amod_index_src
  import amod_pkg::*;
(
  input  logic [DIG_W-1:0] digit,
  input  logic [AW-1:0]    pc_q,
  input  logic [AW-1:0]    t_q,
  input  logic [AW-1:0]    mem_data,
  output src_e             src,
  output logic [AW-1:0]    slot_addr,
  output logic [AW-1:0]    idx
);
  always_comb begin
    src       = digit_src(digit);
    slot_addr = slot_base(digit);
    case (src)
      SRC_PC:  idx = pc_q;
      SRC_T:   idx = t_q;
      SRC_MEM: idx = mem_data;
      default: idx = '0;
    endcase
  end
endmodule

// File: rtl/amod_seq.sv
module amod_seq
  import amod_pkg::*;
#(
  parameter int DEC_TICKS   = 2,
  parameter int MOD_TICKS   = 6,
  parameter int STORE_TICKS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIG_W-1:0] dig_a_in,
  input  logic [DIG_W-1:0] dig_b_in,
  input  logic             store_in,
  input  logic             idx_avail,
  output logic             accept,
  output logic             busy,
  output logic             done,
  output logic             in_mod_b,
  output logic             idx_wait,
  output logic             take_idx,
  output logic [DIG_W-1:0] cur_digit
);
  localparam int MAXT = (MOD_TICKS > DEC_TICKS)
                        ? ((MOD_TICKS > STORE_TICKS) ? MOD_TICKS : STORE_TICKS)
                        : ((DEC_TICKS > STORE_TICKS) ? DEC_TICKS : STORE_TICKS);
  localparam int CW = $clog2(MAXT + 1);

  phase_e           ph_q, ph_n, follow;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             have_q, have_n;
  logic [DIG_W-1:0] dig_a_q, dig_b_q;
  logic             store_q;
  logic             in_mod, phase_end;

  function automatic logic [CW-1:0] last_tick(input phase_e p);
    case (p)
      PH_DECODE:          return CW'(DEC_TICKS - 1);
      PH_MOD_A, PH_MOD_B: return CW'(MOD_TICKS - 1);
      PH_STORE:           return CW'(STORE_TICKS - 1);
      default:            return '0;
    endcase
  endfunction

  // Phase that follows the current one once it ends.
  always_comb begin
    case (ph_q)
      PH_DECODE: follow = (dig_a_q != '0) ? PH_MOD_A :
                          (dig_b_q != '0) ? PH_MOD_B :
                          store_q ? PH_STORE : PH_IDLE;
      PH_MOD_A:  follow = (dig_b_q != '0) ? PH_MOD_B :
                          store_q ? PH_STORE : PH_IDLE;
      PH_MOD_B:  follow = store_q ? PH_STORE : PH_IDLE;
      default:   follow = PH_IDLE;
    endcase
  end

  always_comb begin
    ph_n      = ph_q;
    cnt_n     = cnt_q;
    have_n    = have_q;
    in_mod    = (ph_q == PH_MOD_A) || (ph_q == PH_MOD_B);
    in_mod_b  = (ph_q == PH_MOD_B);
    busy      = (ph_q != PH_IDLE);
    accept    = (ph_q == PH_IDLE) && start;
    idx_wait  = in_mod && !have_q;
    take_idx  = idx_wait && idx_avail;
    phase_end = busy && (cnt_q == '0) && (!in_mod || have_q);
    done      = phase_end && (follow == PH_IDLE);
    cur_digit = in_mod_b ? dig_b_q : dig_a_q;
    if (take_idx) have_n = 1'b1;
    if (accept) begin
      ph_n  = PH_DECODE;
      cnt_n = last_tick(PH_DECODE);
    end else if (phase_end) begin
      ph_n   = follow;
      cnt_n  = last_tick(follow);
      have_n = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      have_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      have_q <= have_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_a_q <= '0;
      dig_b_q <= '0;
      store_q <= 1'b0;
    end else if (accept) begin
      dig_a_q <= dig_a_in;
      dig_b_q <= dig_b_in;
      store_q <= store_in;
    end
  end
endmodule

// File: rtl/addr_mod_seq.sv
module addr_mod_seq
  import amod_pkg::*;
#(
  parameter int DEC_TICKS   = 2,
  parameter int MOD_TICKS   = 6,
  parameter int STORE_TICKS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   a_field,
  input  logic [AW-1:0]   b_field,
  input  logic [CHAR_W-1:0] n_field,
  input  logic            store_en,
  input  logic [AW-1:0]   pc_val,
  input  logic [AW-1:0]   t_val,
  output logic            mem_rd_req,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [AW-1:0]   mem_rd_data,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   eff_a,
  output logic [AW-1:0]   eff_b
);
  localparam int DA_MSB = CHAR_W - 1;
  localparam int DB_MSB = DIG_W - 1;

  logic [1:0]       rs_q;
  logic             rst_s_n;
  logic             accept, in_mod_b, idx_wait, take_idx, idx_avail;
  logic [DIG_W-1:0] cur_digit;
  src_e             src;
  logic [AW-1:0]    idx, slot_addr;
  logic [AW-1:0]    a_q, b_q, pc_q, t_q, a_d, b_d;
  logic             a_en, b_en;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  amod_seq #(
    .DEC_TICKS(DEC_TICKS), .MOD_TICKS(MOD_TICKS), .STORE_TICKS(STORE_TICKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start     (start),
    .dig_a_in  (n_field[DA_MSB -: DIG_W]),
    .dig_b_in  (n_field[DB_MSB -: DIG_W]),
    .store_in  (store_en),
    .idx_avail (idx_avail),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .in_mod_b  (in_mod_b),
    .idx_wait  (idx_wait),
    .take_idx  (take_idx),
    .cur_digit (cur_digit)
  );

  amod_index_src u_src (
    .digit     (cur_digit),
    .pc_q      (pc_q),
    .t_q       (t_q),
    .mem_data  (mem_rd_data),
    .src       (src),
    .slot_addr (slot_addr),
    .idx       (idx)
  );

  always_comb begin
    idx_avail   = (src == SRC_PC) || (src == SRC_T) ||
                  ((src == SRC_MEM) && mem_rd_valid);
    mem_rd_req  = idx_wait && (src == SRC_MEM);
    mem_rd_addr = slot_addr;
    a_en        = accept || (take_idx && !in_mod_b);
    b_en        = accept || (take_idx && in_mod_b);
    a_d         = accept ? a_field : a_q + idx;
    b_d         = accept ? b_field : b_q + idx;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) a_q <= '0;
    else if (a_en) a_q <= a_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) b_q <= '0;
    else if (b_en) b_q <= b_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pc_q <= '0;
      t_q  <= '0;
    end else if (accept) begin
      pc_q <= pc_val;
      t_q  <= t_val;
    end
  end

  assign eff_a = a_q;
  assign eff_b = b_q;
endmodule

// File: rtl/amod_chk.sv
module amod_chk
  import amod_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_rd_req,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_rd_valid,
  input logic [AW-1:0] eff_a,
  input logic [AW-1:0] eff_b
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R6
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> busy); // R3
  AST_REQ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr == 18'd111 || mem_rd_addr == 18'd221 ||
                    mem_rd_addr == 18'd131 || mem_rd_addr == 18'd151 ||
                    mem_rd_addr == 18'd171)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr))); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(eff_a) && $stable(eff_b))); // R11
endmodule

bind addr_mod_seq amod_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_valid (mem_rd_valid),
  .eff_a        (eff_a),
  .eff_b        (eff_b)
);

// File: tb/addr_mod_seq_test.sv
`timescale 1ns/1ps
module addr_mod_seq_test;
  localparam int MASK = 32'h3FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [17:0] a_field = '0, b_field = '0, pc_val = '0, t_val = '0;
  logic [5:0]  n_field = '0;
  logic        store_en = 1'b0;
  logic        mem_rd_req, mem_rd_valid = 1'b0;
  logic [17:0] mem_rd_addr, mem_rd_data = '0;
  logic        busy, done;
  logic [17:0] eff_a, eff_b;

  int checks = 0, errors = 0;
  int mem_lat = 1, wcnt = 0;
  int n_req = 0;
  logic [17:0] req_log [0:3];
  logic req_prev = 1'b0;

  always #2 clk = ~clk;

  addr_mod_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_field(a_field), .b_field(b_field),
    .n_field(n_field), .store_en(store_en), .pc_val(pc_val), .t_val(t_val),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .busy(busy), .done(done), .eff_a(eff_a), .eff_b(eff_b)
  );

  function automatic logic [17:0] mval(input logic [17:0] addr);
    return 18'((int'(addr) * 2749 + 777) & MASK);
  endfunction

  function automatic int slot_of(input int d);
    case (d)
      1: return 111; 2: return 221; 3: return 131; 5: return 151; 7: return 171;
      default: return -1;
    endcase
  endfunction

  function automatic logic [17:0] idxv(input int d, input logic [17:0] pc, t);
    if (d == 0) return '0;
    if (d == 4) return pc;
    if (d == 6) return t;
    return mval(18'(slot_of(d)));
  endfunction

  // Memory model with configurable response delay.
  always @(posedge clk) begin
    if (mem_rd_valid) begin
      mem_rd_valid <= 1'b0;
      wcnt <= 0;
    end else if (mem_rd_req) begin
      if (wcnt >= mem_lat - 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mval(mem_rd_addr);
      end else wcnt <= wcnt + 1;
    end
  end

  // Request log, one entry per new request.
  always @(negedge clk) begin
    if (mem_rd_req && !req_prev && n_req < 4) begin
      req_log[n_req] = mem_rd_addr;
      n_req = n_req + 1;
    end
    req_prev = mem_rd_req;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [17:0] a, b, input int da, db, input bit st,
                     input logic [17:0] pc, t, input int lat, input bit poke);
    int cyc, guard, m_exp, exp_lat, exp_req;
    bit seen;
    logic [17:0] ea, eb, xa, xb;
    logic [17:0] ereq [0:1];
    mem_lat = lat;
    @(negedge clk);
    n_req = 0;
    a_field = a; b_field = b; n_field = 6'(da * 8 + db);
    store_en = st; pc_val = pc; t_val = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a_field = ~a; b_field = ~b; n_field = ~n_field; pc_val = ~pc; t_val = ~t; // R4 sampling
    cyc = 0; guard = 0; seen = 1'b0; ea = '0; eb = '0;
    while (!seen && guard < 300) begin
      guard++;
      if (busy) cyc++;
      if (done) begin
        seen = 1'b1; ea = eff_a; eb = eff_b;
      end else begin
        start = poke && (cyc == 3); // R10 start while busy
        @(negedge clk);
      end
    end
    start = 1'b0;
    xa = 18'((int'(a) + int'(idxv(da, pc, t))) & MASK);
    xb = 18'((int'(b) + int'(idxv(db, pc, t))) & MASK);
    m_exp = 2 + st;
    exp_req = 0;
    if (da != 0) begin
      m_exp += (slot_of(da) > 0 && lat + 2 > 6) ? lat + 2 : 6;
      if (slot_of(da) > 0) begin ereq[exp_req] = 18'(slot_of(da)); exp_req++; end
    end
    if (db != 0) begin
      m_exp += (slot_of(db) > 0 && lat + 2 > 6) ? lat + 2 : 6;
      if (slot_of(db) > 0) begin ereq[exp_req] = 18'(slot_of(db)); exp_req++; end
    end
    exp_lat = m_exp;
    chk("R1/R2/R5 eff_a", {14'd0, ea}, {14'd0, xa});
    chk("R1/R2/R5 eff_b", {14'd0, eb}, {14'd0, xb});
    chk("R6/R7/R9 busy cycles", cyc, exp_lat);
    chk("R8 request count", n_req, exp_req);
    for (int i = 0; i < exp_req; i++)
      if (i < n_req) chk("R3/R8 request address", {14'd0, req_log[i]}, {14'd0, ereq[i]});
    @(negedge clk);
    chk("R6 done single cycle", {30'd0, done, busy}, 32'd0);
    chk("R11 eff_a held", {14'd0, eff_a}, {14'd0, xa});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 reset busy/done/req", {29'd0, busy, done, mem_rd_req}, 32'd0);
    chk("R11 reset eff", {eff_a[15:0], eff_b[15:0]}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Sweep every modifier character with and without the store tick.
    for (int n = 0; n < 64; n++) begin
      for (int s = 0; s < 2; s++) begin
        run(18'(MASK - n * 5 - s), 18'((n * 2897 + s * 131 + 5) & MASK), n / 8, n % 8, s[0],
            18'((n * 613 + 9) & MASK), 18'(MASK - n * 11), 1, 1'b0);
      end
    end

    // R5 wraparound on both addresses
    run(18'h3FFFF, 18'h3FFFE, 4, 6, 1'b0, 18'd1, 18'd5, 1, 1'b0);
    chk("R5 wrap eff_a", {14'd0, eff_a}, 32'd0);
    chk("R5 wrap eff_b", {14'd0, eff_b}, 32'd3);

    // R9 slow memory stretches each memory phase
    run(18'd1000, 18'd2000, 3, 5, 1'b1, 18'd7, 18'd8, 8, 1'b0);
    run(18'd1000, 18'd2000, 2, 7, 1'b0, 18'd7, 18'd8, 4, 1'b0);
    run(18'd40, 18'd50, 1, 4, 1'b0, 18'd7, 18'd8, 12, 1'b0);

    // R10 start pulses during a running sequence are ignored
    run(18'd300, 18'd400, 7, 6, 1'b1, 18'd21, 18'd22, 1, 1'b1);
    run(18'd300, 18'd400, 0, 0, 1'b0, 18'd21, 18'd22, 1, 1'b1);
    run(18'd300, 18'd400, 0, 2, 1'b1, 18'd21, 18'd22, 1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule